// File: doc/BRIEF.md
# Segmented Thermometer Control Word Register

This block holds the control word for a switch array that sets the current of a digitally regulated supply. The word is kept in three unary segments: low, medium and high. Each segment is a thermometer vector, so moving the word by one step toggles a single switch inside a segment. Each segment also reports its fill level as a binary count. A low bit is worth one unit of current. A medium bit is worth a full low segment. A high bit is worth a full medium segment times a full low segment.

Two command pairs drive the word. The fine pair moves the low segment. When the low segment runs off either end, it reloads and passes one step to the medium segment. The coarse pair moves the medium segment directly. When the medium segment runs off either end, it passes one step to the high segment and reloads to an inner fill level rather than wrapping to its opposite end. This limits the current disturbance seen during the handover. A clock-enable lets the outer regulation loop choose the update rate. Only one step is taken per enabled cycle.

With default sizes, the coarse word is `h*4 + m` and the overall word is `coarse*8 + l`.

Top module: `seg_therm_word`

## Requirements
- R1: A synchronous active-high reset clears all three counts (`cnt_lo`, `cnt_mid`, `cnt_hi`) and all three thermometer vectors to zero.
- R2: In every thermometer vector, bit i is 1 exactly when i is below that segment's count, so bit 0 fills first; the number of ones equals the count.
- R3: With the enable high and only `fine_up` (or only `fine_dn`) asserted, and with `cnt_lo` strictly inside 0..8, `cnt_lo` moves up (down) by one on the next clock. The overall word moves by one, and the medium and high counts are unchanged.
- R4: A fine up request with `cnt_lo`=8 sets `cnt_lo` to 1 and applies one medium up step under the coarse rules. A fine down request with `cnt_lo`=0, when the medium or high count is nonzero, sets `cnt_lo` to 7 and applies one medium down step.
- R5: With the enable high and only `crs_up` asserted and `cnt_mid`<4, `cnt_mid` rises by one; with only `crs_dn` and `cnt_mid`>0, it falls by one. In both cases the low and high counts are unchanged, so the overall word moves by 8.
- R6: A medium up step with `cnt_mid`=4 and `cnt_hi`<16 sets `cnt_mid` to 3 and raises `cnt_hi` by one, taking the coarse word from 4h+4 to 4h+7.
- R7: A medium down step with `cnt_mid`=0 and `cnt_hi`>0 sets `cnt_mid` to 1 and lowers `cnt_hi` by one.
- R8: With all counts at maximum (8, 4, 16), up requests change nothing. With all counts zero, down requests change nothing.
- R9: A pair with both members asserted is treated as no request. When the coarse pair is contradictory, a valid fine request still acts.
- R10: When both pairs hold a valid request in the same cycle, the coarse request acts and the fine request is dropped: `cnt_lo` keeps its value.
- R11: While the enable is low, no count or vector changes, whatever the command inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Update enable; one step per enabled cycle |
| fine_up | input | 1 | Fine step up request |
| fine_dn | input | 1 | Fine step down request |
| crs_up | input | 1 | Coarse step up request |
| crs_dn | input | 1 | Coarse step down request |
| therm_lo | output | LEN_LO (8) | Low segment thermometer vector |
| therm_mid | output | LEN_MID (4) | Medium segment thermometer vector |
| therm_hi | output | LEN_HI (16) | High segment thermometer vector |
| cnt_lo | output | $clog2(LEN_LO+1) (4) | Low segment fill count |
| cnt_mid | output | $clog2(LEN_MID+1) (3) | Medium segment fill count |
| cnt_hi | output | $clog2(LEN_HI+1) (5) | High segment fill count |

## Verification
The assertions assume the command inputs and the enable hold clean 0/1 values whenever reset is low. They also assume reset is asserted from the first clock, so the counts are known before any step is judged. The bench holds reset high from time zero and changes inputs only on the falling clock edge, always to defined levels. It walks the word to both extremes through every carry, borrow and saturation case, so each guarded transition is reached with a settled state.

// File: rtl/seg_word_pkg.sv
package seg_word_pkg;

  // Per-cycle command applied to one thermometer segment
  typedef enum logic [1:0] {
    SEG_HOLD = 2'd0,
    SEG_INC  = 2'd1,
    SEG_DEC  = 2'd2,
    SEG_LOAD = 2'd3
  } seg_op_e;

endpackage

// File: rtl/therm_seg.sv
module therm_seg
  import seg_word_pkg::*;
#(
  parameter int LEN = 8,
  parameter int CW  = $clog2(LEN + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  seg_op_e        op,
  input  logic [CW-1:0]  load_val,
  output logic [LEN-1:0] therm_o,
  output logic [CW-1:0]  cnt_o
);

  localparam logic [CW-1:0] FULL = CW'(LEN);

  logic [CW-1:0]  fill_d;
  logic [LEN-1:0] therm_d;
  logic [LEN-1:0] therm_q;
  logic [CW-1:0]  cnt_q;

  always_comb begin
    case (op)
      SEG_INC:  fill_d = cnt_q + CW'(1);
      SEG_DEC:  fill_d = cnt_q - CW'(1);
      SEG_LOAD: fill_d = load_val;
      default:  fill_d = cnt_q;
    endcase
  end

  // Each shift bit gets its own set/clear decision, so any fill level loads in one cycle
  for (genvar i = 0; i < LEN; i++) begin : g_bit
    assign therm_d[i] = (fill_d > CW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      therm_q <= '0;
      cnt_q   <= '0;
    end else begin
      therm_q <= therm_d;
      cnt_q   <= fill_d;
    end
  end

  assign therm_o = therm_q;
  assign cnt_o   = cnt_q;

  // R2
  therm_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(therm_q) == int'(cnt_q));

  // R2
  therm_shape_chk: assert property (@(posedge clk) disable iff (rst)
    ((therm_q >> 1) & ~therm_q) == '0);

  // R8
  seg_room_chk: assert property (@(posedge clk) disable iff (rst)
    (op == SEG_INC) |-> (cnt_q != FULL));

  // R8
  seg_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (op == SEG_DEC) |-> (cnt_q != '0));

endmodule

// File: rtl/word_step_ctrl.sv
module word_step_ctrl
  import seg_word_pkg::*;
#(
  parameter int LEN_LO  = 8,
  parameter int LEN_MID = 4,
  parameter int LEN_HI  = 16,
  parameter int MID_CI_LOAD = LEN_MID - 1,
  parameter int MID_CO_LOAD = 1,
  parameter int LW = $clog2(LEN_LO + 1),
  parameter int MW = $clog2(LEN_MID + 1),
  parameter int HW = $clog2(LEN_HI + 1)
) (
  input  logic          ce,
  input  logic          fine_up,
  input  logic          fine_dn,
  input  logic          crs_up,
  input  logic          crs_dn,
  input  logic [LW-1:0] cnt_lo,
  input  logic [MW-1:0] cnt_mid,
  input  logic [HW-1:0] cnt_hi,
  output seg_op_e       op_lo,
  output seg_op_e       op_mid,
  output seg_op_e       op_hi,
  output logic [LW-1:0] load_lo,
  output logic [MW-1:0] load_mid
);

  localparam logic [LW-1:0] L_MAX   = LW'(LEN_LO);
  localparam logic [LW-1:0] L_UPLD  = LW'(1);
  localparam logic [LW-1:0] L_DNLD  = LW'(LEN_LO - 1);
  localparam logic [MW-1:0] M_MAX   = MW'(LEN_MID);
  localparam logic [MW-1:0] M_CI    = MW'(MID_CI_LOAD);
  localparam logic [MW-1:0] M_CO    = MW'(MID_CO_LOAD);
  localparam logic [HW-1:0] H_MAX   = HW'(LEN_HI);

  logic c_up, c_dn, f_up, f_dn, c_act;
  logic mid_up, mid_dn, mid_ok;

  always_comb begin
    c_up  = crs_up & ~crs_dn;
    c_dn  = crs_dn & ~crs_up;
    f_up  = fine_up & ~fine_dn;
    f_dn  = fine_dn & ~fine_up;
    c_act = c_up | c_dn;

    // Medium step requested either directly or by a low-segment overflow
    mid_up = ce & (c_up | (~c_act & f_up & (cnt_lo == L_MAX)));
    mid_dn = ce & (c_dn | (~c_act & f_dn & (cnt_lo == '0)));

    op_mid   = SEG_HOLD;
    op_hi    = SEG_HOLD;
    load_mid = M_CI;
    mid_ok   = 1'b0;
    if (mid_up) begin
      if (cnt_mid != M_MAX) begin
        op_mid = SEG_INC;
        mid_ok = 1'b1;
      end else if (cnt_hi != H_MAX) begin
        op_mid   = SEG_LOAD;
        load_mid = M_CI;
        op_hi    = SEG_INC;
        mid_ok   = 1'b1;
      end
    end else if (mid_dn) begin
      if (cnt_mid != '0) begin
        op_mid = SEG_DEC;
        mid_ok = 1'b1;
      end else if (cnt_hi != '0) begin
        op_mid   = SEG_LOAD;
        load_mid = M_CO;
        op_hi    = SEG_DEC;
        mid_ok   = 1'b1;
      end
    end

    op_lo   = SEG_HOLD;
    load_lo = L_UPLD;
    if (ce & ~c_act & f_up) begin
      if (cnt_lo != L_MAX) begin
        op_lo = SEG_INC;
      end else if (mid_ok) begin
        op_lo   = SEG_LOAD;
        load_lo = L_UPLD;
      end
    end else if (ce & ~c_act & f_dn) begin
      if (cnt_lo != '0) begin
        op_lo = SEG_DEC;
      end else if (mid_ok) begin
        op_lo   = SEG_LOAD;
        load_lo = L_DNLD;
      end
    end
  end

endmodule

// File: rtl/seg_therm_word.sv
module seg_therm_word
  import seg_word_pkg::*;
#(
  parameter int LEN_LO  = 8,
  parameter int LEN_MID = 4,
  parameter int LEN_HI  = 16,
  parameter int MID_CI_LOAD = LEN_MID - 1,
  parameter int MID_CO_LOAD = 1,
  localparam int LW = $clog2(LEN_LO + 1),
  localparam int MW = $clog2(LEN_MID + 1),
  localparam int HW = $clog2(LEN_HI + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              fine_up,
  input  logic              fine_dn,
  input  logic              crs_up,
  input  logic              crs_dn,
  output logic [LEN_LO-1:0]  therm_lo,
  output logic [LEN_MID-1:0] therm_mid,
  output logic [LEN_HI-1:0]  therm_hi,
  output logic [LW-1:0]      cnt_lo,
  output logic [MW-1:0]      cnt_mid,
  output logic [HW-1:0]      cnt_hi
);

  localparam logic [LW-1:0] L_MAX = LW'(LEN_LO);
  localparam logic [MW-1:0] M_MAX = MW'(LEN_MID);
  localparam logic [MW-1:0] M_CI  = MW'(MID_CI_LOAD);
  localparam logic [MW-1:0] M_CO  = MW'(MID_CO_LOAD);
  localparam logic [HW-1:0] H_MAX = HW'(LEN_HI);

  seg_op_e       op_lo, op_mid, op_hi;
  logic [LW-1:0] load_lo;
  logic [MW-1:0] load_mid;

  word_step_ctrl #(
    .LEN_LO(LEN_LO), .LEN_MID(LEN_MID), .LEN_HI(LEN_HI),
    .MID_CI_LOAD(MID_CI_LOAD), .MID_CO_LOAD(MID_CO_LOAD)
  ) u_ctrl (
    .ce(ce), .fine_up(fine_up), .fine_dn(fine_dn),
    .crs_up(crs_up), .crs_dn(crs_dn),
    .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .cnt_hi(cnt_hi),
    .op_lo(op_lo), .op_mid(op_mid), .op_hi(op_hi),
    .load_lo(load_lo), .load_mid(load_mid)
  );

  therm_seg #(.LEN(LEN_LO)) u_lo (
    .clk(clk), .rst(rst), .op(op_lo), .load_val(load_lo),
    .therm_o(therm_lo), .cnt_o(cnt_lo)
  );

  therm_seg #(.LEN(LEN_MID)) u_mid (
    .clk(clk), .rst(rst), .op(op_mid), .load_val(load_mid),
    .therm_o(therm_mid), .cnt_o(cnt_mid)
  );

  therm_seg #(.LEN(LEN_HI)) u_hi (
    .clk(clk), .rst(rst), .op(op_hi), .load_val('0),
    .therm_o(therm_hi), .cnt_o(cnt_hi)
  );

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(cnt_lo) && $stable(cnt_mid) && $stable(cnt_hi)));

  // R6
  carry_in_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && crs_up && !crs_dn && cnt_mid == M_MAX && cnt_hi != H_MAX)
    |=> (cnt_mid == M_CI && cnt_hi == HW'($past(cnt_hi) + HW'(1)) && $stable(cnt_lo)));

  // R7
  carry_out_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && crs_dn && !crs_up && cnt_mid == '0 && cnt_hi != '0)
    |=> (cnt_mid == M_CO && cnt_hi == HW'($past(cnt_hi) - HW'(1)) && $stable(cnt_lo)));

  // R8
  top_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && cnt_lo == L_MAX && cnt_mid == M_MAX && cnt_hi == H_MAX &&
     !crs_dn && !(fine_dn && !fine_up && !crs_up))
    |=> ($stable(cnt_lo) && $stable(cnt_mid) && $stable(cnt_hi)));

  // R10
  coarse_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && (crs_up ^ crs_dn)) |=> $stable(cnt_lo));

  // R3
  fine_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && !crs_up && !crs_dn && (fine_up ^ fine_dn) && cnt_lo != '0 && cnt_lo != L_MAX)
    |=> ($stable(cnt_mid) && $stable(cnt_hi)));

endmodule

// File: tb/sim_seg_therm_word.sv
module sim_seg_therm_word;

  localparam int LL = 8;
  localparam int LM = 4;
  localparam int LH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, fine_up = 1'b0, fine_dn = 1'b0, crs_up = 1'b0, crs_dn = 1'b0;
  logic [LL-1:0] therm_lo;
  logic [LM-1:0] therm_mid;
  logic [LH-1:0] therm_hi;
  logic [3:0] cnt_lo;
  logic [2:0] cnt_mid;
  logic [4:0] cnt_hi;

  int nchk = 0;
  int nfail = 0;
  int el = 0, em = 0, eh = 0;

  seg_therm_word u0 (
    .clk(clk), .rst(rst), .ce(ce), .fine_up(fine_up), .fine_dn(fine_dn),
    .crs_up(crs_up), .crs_dn(crs_dn),
    .therm_lo(therm_lo), .therm_mid(therm_mid), .therm_hi(therm_hi),
    .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .cnt_hi(cnt_hi)
  );

  always #5 clk = ~clk;

  task automatic cmp(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int word_now();
    return (int'(cnt_hi) * LM + int'(cnt_mid)) * LL + int'(cnt_lo);
  endfunction

  // Medium step per the coarse rules; returns 1 when the step happened
  function automatic bit mid_step(bit up);
    if (up) begin
      if (em < LM) begin em++; return 1; end
      if (eh < LH) begin eh++; em = LM - 1; return 1; end
      return 0;
    end
    if (em > 0) begin em--; return 1; end
    if (eh > 0) begin eh--; em = 1; return 1; end
    return 0;
  endfunction

  task automatic compare_all();
    cmp("R2 low count", int'(cnt_lo), el);
    cmp("R2 mid count", int'(cnt_mid), em);
    cmp("R2 high count", int'(cnt_hi), eh);
    cmp("R2 low thermometer", int'(therm_lo), (1 << el) - 1);
    cmp("R2 mid thermometer", int'(therm_mid), (1 << em) - 1);
    cmp("R2 high thermometer", int'(therm_hi), (1 << eh) - 1);
  endtask

  task automatic apply(bit e, bit fu, bit fd, bit cu, bit cd);
    bit cv, ok;
    @(negedge clk);
    ce = e; fine_up = fu; fine_dn = fd; crs_up = cu; crs_dn = cd;
    @(posedge clk);
    #1;
    cv = cu ^ cd;
    if (e) begin
      if (cv) ok = mid_step(cu);
      else if (fu && !fd) begin
        if (el < LL) el++;
        else if (mid_step(1)) el = 1;
      end else if (fd && !fu) begin
        if (el > 0) el--;
        else if (mid_step(0)) el = LL - 1;
      end
    end
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ce = 0; fine_up = 0; fine_dn = 0; crs_up = 0; crs_dn = 0;
    repeat (2) @(posedge clk);
    #1;
    el = 0; em = 0; eh = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    cmp("R1 low count after reset", int'(cnt_lo), 0);
    cmp("R1 mid count after reset", int'(cnt_mid), 0);
    cmp("R1 high count after reset", int'(cnt_hi), 0);
    cmp("R1 thermometers after reset", int'(therm_lo) + int'(therm_mid) + int'(therm_hi), 0);
  endtask

  task automatic t_fine_r3();
    int w;
    do_reset();
    for (int i = 0; i < 5; i++) apply(1, 1, 0, 0, 0);
    cmp("R3 low after 5 ups", int'(cnt_lo), 5);
    w = word_now();
    apply(1, 0, 1, 0, 0);
    cmp("R3 word down by one", word_now(), w - 1);
    apply(1, 1, 0, 0, 0);
    cmp("R3 word up by one", word_now(), w);
  endtask

  task automatic t_fine_carry_r4();
    int w;
    do_reset();
    for (int i = 0; i < 8; i++) apply(1, 1, 0, 0, 0);
    w = word_now();
    apply(1, 1, 0, 0, 0);
    cmp("R4 carry low reload", int'(cnt_lo), 1);
    cmp("R4 carry mid step", int'(cnt_mid), 1);
    cmp("R4 carry word +1", word_now(), w + 1);
    apply(1, 0, 1, 0, 0);
    w = word_now();
    apply(1, 0, 1, 0, 0);
    cmp("R4 borrow low reload", int'(cnt_lo), 7);
    cmp("R4 borrow mid step", int'(cnt_mid), 0);
    cmp("R4 borrow word -1", word_now(), w - 1);
    // fine carry with medium full passes into high
    for (int i = 0; i < 4; i++) apply(1, 0, 0, 1, 0);
    apply(1, 1, 0, 0, 0);
    apply(1, 1, 0, 0, 0);
    cmp("R4 fine carry through mid=4 high", int'(cnt_hi), 1);
    cmp("R4 fine carry through mid=4 mid", int'(cnt_mid), 3);
  endtask

  task automatic t_coarse_r5();
    int w;
    do_reset();
    apply(1, 1, 0, 0, 0);
    apply(1, 1, 0, 0, 0);
    w = word_now();
    apply(1, 0, 0, 1, 0);
    apply(1, 0, 0, 1, 0);
    cmp("R5 mid after two coarse ups", int'(cnt_mid), 2);
    cmp("R5 low unchanged", int'(cnt_lo), 2);
    cmp("R5 word moved by 16", word_now(), w + 16);
    apply(1, 0, 0, 0, 1);
    cmp("R5 mid after coarse down", int'(cnt_mid), 1);
  endtask

  task automatic t_carry_r6_r7();
    do_reset();
    for (int i = 0; i < 4; i++) apply(1, 0, 0, 1, 0);
    apply(1, 0, 0, 1, 0);
    cmp("R6 carry-in mid", int'(cnt_mid), 3);
    cmp("R6 carry-in high", int'(cnt_hi), 1);
    cmp("R6 coarse word 4 to 7", int'(cnt_hi) * LM + int'(cnt_mid), 7);
    for (int i = 0; i < 3; i++) apply(1, 0, 0, 0, 1);
    apply(1, 0, 0, 0, 1);
    cmp("R7 carry-out mid", int'(cnt_mid), 1);
    cmp("R7 carry-out high", int'(cnt_hi), 0);
  endtask

  task automatic t_sat_r8();
    do_reset();
    apply(1, 0, 1, 0, 0);
    apply(1, 0, 0, 0, 1);
    cmp("R8 bottom holds word", word_now(), 0);
    for (int i = 0; i < 70; i++) apply(1, 0, 0, 1, 0);
    for (int i = 0; i < 10; i++) apply(1, 1, 0, 0, 0);
    cmp("R8 top low", int'(cnt_lo), 8);
    cmp("R8 top mid", int'(cnt_mid), 4);
    cmp("R8 top high", int'(cnt_hi), 16);
    apply(1, 0, 0, 1, 0);
    cmp("R8 top coarse up holds", word_now(), (16 * 4 + 4) * 8 + 8);
  endtask

  task automatic t_pairs_r9_r10();
    do_reset();
    apply(1, 1, 0, 0, 0);
    apply(1, 1, 1, 0, 0);
    cmp("R9 contradictory fine ignored", int'(cnt_lo), 1);
    apply(1, 0, 0, 1, 1);
    cmp("R9 contradictory coarse ignored mid", int'(cnt_mid), 0);
    apply(1, 1, 0, 1, 1);
    cmp("R9 fine acts under contradictory coarse", int'(cnt_lo), 2);
    apply(1, 1, 0, 1, 0);
    cmp("R10 coarse wins mid", int'(cnt_mid), 1);
    cmp("R10 fine dropped", int'(cnt_lo), 2);
  endtask

  task automatic t_enable_r11();
    do_reset();
    apply(1, 0, 0, 1, 0);
    apply(0, 1, 0, 0, 0);
    apply(0, 0, 0, 1, 0);
    apply(0, 0, 1, 0, 1);
    cmp("R11 low held while disabled", int'(cnt_lo), 0);
    cmp("R11 mid held while disabled", int'(cnt_mid), 1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nfail++;
        $display("FAIL watchdog (all requirements) actual=%0d expected<=%0d cycles", cyc, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_fine_r3();
    t_fine_carry_r4();
    t_coarse_r5();
    t_carry_r6_r7();
    t_sat_r8();
    t_pairs_r9_r10();
    t_enable_r11();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule